// File: doc/BRIEF.md
# Interrupt Destination Address Matcher

This block decides, for every interrupt message presented to it, whether the local interrupt unit it belongs to is one of the message's targets. A request carries a two-bit destination shorthand, a physical/logical select and a destination field. The block compares these against the unit's own identity, which is held in three programmable registers: an identifier, a logical destination word and a destination format word. It also uses a flag that says whether the request was sent by this same unit. The verdict is a single registered match bit. A second registered bit reports a request that could not be decoded because the destination format holds an unknown logical model.

Two addressing modes are supported. In compact mode the identifier and the logical identifier are 8 bits wide. Logical matching then follows either a flat model, where the identifier is a bit mask, or a cluster model, where the upper nibble names a cluster and the lower nibble a member mask. In extended mode the destination is a full 32-bit word. The logical destination word is then generated from the identifier and is no longer taken from software, and the identity registers are frozen against writes.

The registers are written through a simple select/data port and are visible on read-back outputs. Arbitration among several matching units and the delivery of the interrupt happen elsewhere.

Top module: `irq_dest_match`

## Requirements
- R1: After reset the identifier reads RESET_ID (default 8'h03), the logical word reads 0, the format word reads 32'hFFFFFFFF (flat model), and match and model_err are 0.
- R2: match and model_err reflect the request present before a rising clock edge and are valid right after that edge. They are evaluated against the register state from before any write taken at the same edge.
- R3: With shorthand 2'd0 and req_logical=0 in compact mode, match is 1 when req_dest[7:0] is 8'hFF or equals the identifier, and 0 otherwise.
- R4: With shorthand 2'd0 and req_logical=0 in extended mode, match is 1 when all 32 bits of req_dest equal 32'h000000FF or the zero-extended identifier, and 0 otherwise.
- R5: With shorthand 2'd0 and req_logical=1 in compact mode, when format bits [31:28] are 4'hF (flat), match is 1 when logical word bits [31:24] AND req_dest[7:0] is nonzero.
- R6: In the same case with format bits [31:28] at 4'h0 (cluster), match is 1 when bits [7:4] of the logical identifier and of req_dest are equal and bits [3:0] of the two share a set bit.
- R7: In the same case with any other value of format bits [31:28], match is 0 and model_err is 1. model_err is 0 for every other request.
- R8: Shorthand 2'd1 matches only when req_from_self is 1, 2'd2 always matches, and 2'd3 matches only when req_from_self is 0. These ignore req_logical, req_dest and the registers.
- R9: In extended mode logical matching ANDs all 32 bits of req_dest with the generated word ({identifier[7:4]} at bits [23:20], a one at bit position identifier[3:0], zeros elsewhere). Each cycle with ext_mode=1 the logical word register is loaded with that generated word.
- R10: cfg_sel selects the target of a write: 0 identifier (from wr data [31:24]), 1 logical word (bits [31:24] kept, [23:0] cleared), 2 format word (bits [27:0] forced to ones), 3 no register.
- R11: While ext_mode=1, writes to the identifier and the format word have no effect. A logical-word write is replaced by the generated word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 ID, 1 logical word, 2 format word, 3 none |
| cfg_wdata | input | 32 | Register write data |
| ext_mode | input | 1 | 1 selects extended addressing |
| req_short | input | 2 | Shorthand: 0 none, 1 self, 2 all, 3 all but self |
| req_logical | input | 1 | 1 logical destination, 0 physical |
| req_dest | input | 32 | Destination field |
| req_from_self | input | 1 | Request was sent by this unit |
| match | output | 1 | Registered verdict: this unit is a target |
| model_err | output | 1 | Registered flag: unknown logical model seen |
| cfg_id | output | 8 | Identifier register |
| cfg_ldr | output | 32 | Logical destination register |
| cfg_dfr | output | 32 | Destination format register |

## Verification
Some cases are hard to reach from the ports. One is a compact logical request whose destination falls in the unit's own cluster, with a member mask that just touches or just misses the logical identifier. The others are requests that meet an undefined format model, and extended-mode destinations whose low byte matches the identifier while the upper bytes do not. Uniformly random destinations almost never produce these. The random stimulus therefore builds most destinations from the bench's own copy of the identity registers, keeping the cluster nibble and flipping member bits. Format writes are weighted toward flat, cluster and arbitrary model nibbles. Directed steps cover each of these corners once before the random phase begins.

// File: rtl/irqdm_pkg.sv
package irqdm_pkg;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef enum logic [1:0] {
    SEL_ID   = 2'd0,
    SEL_LDR  = 2'd1,
    SEL_DFR  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;

  typedef struct packed {
    logic hit;
    logic bad_model;
  } verdict_t;

endpackage

// File: rtl/irqdm_regs.sv
module irqdm_regs
  import irqdm_pkg::*;
#(
  parameter int           ID_W     = 8,
  parameter int           REG_W    = 32,
  parameter logic [7:0]   RESET_ID = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             ext_mode,
  output logic [ID_W-1:0]  id_q,
  output logic [REG_W-1:0] ldr_q,
  output logic [REG_W-1:0] dfr_q,
  output logic [REG_W-1:0] ldr_gen
);

  localparam int SLOT_W   = 4;
  localparam int SLOTS    = 1 << SLOT_W;
  localparam int CL_W     = ID_W - SLOT_W;
  localparam int CL_LSB   = SLOTS + SLOT_W;
  localparam int MODEL_W  = 4;
  localparam logic [REG_W-1:0] LDR_KEEP  = {{ID_W{1'b1}}, {(REG_W-ID_W){1'b0}}};
  localparam logic [REG_W-1:0] DFR_FORCE = {{MODEL_W{1'b0}}, {(REG_W-MODEL_W){1'b1}}};

  // Generated logical word for extended mode: cluster field plus one-hot slot.
  logic [SLOTS-1:0] slot_hot;
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_hot[s] = (id_q[SLOT_W-1:0] == SLOT_W'(s));
  end

  always_comb begin
    ldr_gen                  = '0;
    ldr_gen[SLOTS-1:0]       = slot_hot;
    ldr_gen[CL_LSB +: CL_W]  = id_q[ID_W-1:SLOT_W];
  end

  // Next-state
  logic             id_en, ldr_en, dfr_en;
  logic [ID_W-1:0]  id_d;
  logic [REG_W-1:0] ldr_d, dfr_d;

  always_comb begin
    id_en  = we && (cfg_sel_e'(sel) == SEL_ID)  && !ext_mode;
    dfr_en = we && (cfg_sel_e'(sel) == SEL_DFR) && !ext_mode;
    ldr_en = ext_mode || (we && (cfg_sel_e'(sel) == SEL_LDR));
    id_d   = wdata[REG_W-1 -: ID_W];
    dfr_d  = wdata | DFR_FORCE;
    ldr_d  = ext_mode ? ldr_gen : (wdata & LDR_KEEP);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= RESET_ID[ID_W-1:0];
      ldr_q <= '0;
      dfr_q <= '1;
    end else begin
      if (id_en)  id_q  <= id_d;
      if (ldr_en) ldr_q <= ldr_d;
      if (dfr_en) dfr_q <= dfr_d;
    end
  end

endmodule

// File: rtl/irqdm_physical.sv
module irqdm_physical #(
  parameter int ID_W  = 8,
  parameter int REG_W = 32
) (
  input  logic             ext_mode,
  input  logic [REG_W-1:0] dest,
  input  logic [ID_W-1:0]  id,
  output logic             hit
);

  localparam logic [ID_W-1:0] BCAST = '1;

  logic short_hit, wide_hit;

  always_comb begin
    short_hit = (dest[ID_W-1:0] == BCAST) || (dest[ID_W-1:0] == id);
    wide_hit  = (dest == REG_W'(BCAST))   || (dest == REG_W'(id));
    hit       = ext_mode ? wide_hit : short_hit;
  end

endmodule

// File: rtl/irqdm_logical.sv
module irqdm_logical
  import irqdm_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int REG_W = 32
) (
  input  logic             ext_mode,
  input  logic [REG_W-1:0] dest,
  input  logic [REG_W-1:0] ldr_q,
  input  logic [REG_W-1:0] ldr_gen,
  input  logic [3:0]       model,
  output verdict_t         verdict
);

  localparam int NIB = 4;

  logic [ID_W-1:0] lid, mda;
  logic            flat_hit, cluster_hit, wide_hit;

  always_comb begin
    lid         = ldr_q[REG_W-1 -: ID_W];
    mda         = dest[ID_W-1:0];
    flat_hit    = |(lid & mda);
    cluster_hit = (lid[ID_W-1:NIB] == mda[ID_W-1:NIB]) && (|(lid[NIB-1:0] & mda[NIB-1:0]));
    wide_hit    = |(ldr_gen & dest);

    verdict = '0;
    if (ext_mode) begin
      verdict.hit = wide_hit;
    end else begin
      case (model)
        MODEL_FLAT:    verdict.hit = flat_hit;
        MODEL_CLUSTER: verdict.hit = cluster_hit;
        default:       verdict.bad_model = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match
  import irqdm_pkg::*;
#(
  parameter int         ID_W     = 8,
  parameter int         REG_W    = 32,
  parameter logic [7:0] RESET_ID = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             ext_mode,
  input  logic [1:0]       req_short,
  input  logic             req_logical,
  input  logic [REG_W-1:0] req_dest,
  input  logic             req_from_self,
  output logic             match,
  output logic             model_err,
  output logic [ID_W-1:0]  cfg_id,
  output logic [REG_W-1:0] cfg_ldr,
  output logic [REG_W-1:0] cfg_dfr
);

  localparam int MODEL_W = 4;

  logic [ID_W-1:0]  id_q;
  logic [REG_W-1:0] ldr_q, dfr_q, ldr_gen;
  logic             phys_hit;
  verdict_t         log_v;

  irqdm_regs #(.ID_W(ID_W), .REG_W(REG_W), .RESET_ID(RESET_ID)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .ext_mode (ext_mode),
    .id_q     (id_q),
    .ldr_q    (ldr_q),
    .dfr_q    (dfr_q),
    .ldr_gen  (ldr_gen)
  );

  irqdm_physical #(.ID_W(ID_W), .REG_W(REG_W)) u_phys (
    .ext_mode (ext_mode),
    .dest     (req_dest),
    .id       (id_q),
    .hit      (phys_hit)
  );

  irqdm_logical #(.ID_W(ID_W), .REG_W(REG_W)) u_log (
    .ext_mode (ext_mode),
    .dest     (req_dest),
    .ldr_q    (ldr_q),
    .ldr_gen  (ldr_gen),
    .model    (dfr_q[REG_W-1 -: MODEL_W]),
    .verdict  (log_v)
  );

  // Next-state
  logic match_d, err_d;

  always_comb begin
    match_d = 1'b0;
    err_d   = 1'b0;
    case (shorthand_e'(req_short))
      SH_NONE: begin
        if (req_logical) begin
          match_d = log_v.hit;
          err_d   = log_v.bad_model;
        end else begin
          match_d = phys_hit;
        end
      end
      SH_SELF:   match_d = req_from_self;
      SH_ALL:    match_d = 1'b1;
      SH_OTHERS: match_d = !req_from_self;
      default:   match_d = 1'b0;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match     <= 1'b0;
      model_err <= 1'b0;
    end else begin
      match     <= match_d;
      model_err <= err_d;
    end
  end

  assign cfg_id  = id_q;
  assign cfg_ldr = ldr_q;
  assign cfg_dfr = dfr_q;

endmodule

// File: rtl/irq_dest_match_chk.sv
module irq_dest_match_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [1:0]  cfg_sel,
  input logic [31:0] cfg_wdata,
  input logic        ext_mode,
  input logic [1:0]  req_short,
  input logic        req_logical,
  input logic [31:0] req_dest,
  input logic        req_from_self,
  input logic        match,
  input logic        model_err,
  input logic [7:0]  cfg_id,
  input logic [31:0] cfg_ldr,
  input logic [31:0] cfg_dfr
);

  a_r3_phys_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (req_short == 2'd0 && !req_logical && !ext_mode && req_dest[7:0] == 8'hFF) |=> match);

  a_r8_self_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_short == 2'd1) |=> (match == $past(req_from_self)));

  a_r8_all_incl: assert property (@(posedge clk) disable iff (!rst_n)
    (req_short == 2'd2) |=> (match && !model_err));

  a_r8_all_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (req_short == 2'd3) |=> (match == !$past(req_from_self)));

  a_r7_err_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    model_err |-> !match);

  a_r7_err_only_logical: assert property (@(posedge clk) disable iff (!rst_n)
    (req_short != 2'd0 || !req_logical || ext_mode) |=> !model_err);

  a_r11_ext_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && cfg_we) |=> ($stable(cfg_id) && $stable(cfg_dfr)));

  a_r10_dfr_low_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd2 && !ext_mode) |=> (cfg_dfr[27:0] == 28'hFFF_FFFF));

  a_r9_ext_slot_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |=> ($countones(cfg_ldr[15:0]) == 1));

endmodule

bind irq_dest_match irq_dest_match_chk u_chk (.*);

// File: tb/irq_dest_match_bench.sv
module irq_dest_match_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        ext_mode;
  logic [1:0]  req_short;
  logic        req_logical;
  logic [31:0] req_dest;
  logic        req_from_self;
  logic        match;
  logic        model_err;
  logic [7:0]  cfg_id;
  logic [31:0] cfg_ldr;
  logic [31:0] cfg_dfr;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0]  s_id;
  logic [31:0] s_ldr, s_dfr;

  irq_dest_match u_irq_dest_match (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] gen_ldr(input logic [7:0] id);
    logic [31:0] w;
    w = 32'h0;
    w[23:20] = id[7:4];
    w[id[3:0]] = 1'b1;
    return w;
  endfunction

  // Expected {match, model_err} from the requirements
  function automatic logic [1:0] expect_v(input logic [1:0] sh, input logic lg,
                                          input logic [31:0] d, input logic self_f,
                                          input logic ext);
    logic [7:0] lid;
    lid = s_ldr[31:24];
    case (sh)
      2'd1: return {self_f, 1'b0};
      2'd2: return 2'b10;
      2'd3: return {!self_f, 1'b0};
      default: begin
        if (!lg) begin
          if (ext) return {(d == 32'hFF) || (d == {24'h0, s_id}), 1'b0};
          return {(d[7:0] == 8'hFF) || (d[7:0] == s_id), 1'b0};
        end
        if (ext) return {(gen_ldr(s_id) & d) != 0, 1'b0};
        if (s_dfr[31:28] == 4'hF) return {(lid & d[7:0]) != 0, 1'b0};
        if (s_dfr[31:28] == 4'h0)
          return {(lid[7:4] == d[7:4]) && ((lid[3:0] & d[3:0]) != 0), 1'b0};
        return 2'b01;
      end
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_vec++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // One cycle: drive, clock, compare verdict and registers
  task automatic step(input string tag, input logic we, input logic [1:0] sel,
                      input logic [31:0] wd, input logic ext, input logic [1:0] sh,
                      input logic lg, input logic [31:0] d, input logic self_f);
    logic [1:0] ev;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd; ext_mode = ext;
    req_short = sh; req_logical = lg; req_dest = d; req_from_self = self_f;
    ev = expect_v(sh, lg, d, self_f, ext);
    @(posedge clk);
    #1;
    // R2: verdict is the one of the pre-edge request and state
    check({tag, " match"}, {31'h0, match}, {31'h0, ev[1]});
    check({tag, " model_err"}, {31'h0, model_err}, {31'h0, ev[0]});
    if (ext) begin
      s_ldr = gen_ldr(s_id);
    end else if (we) begin
      case (sel)
        2'd0: s_id  = wd[31:24];
        2'd1: s_ldr = wd & 32'hFF00_0000;
        2'd2: s_dfr = wd | 32'h0FFF_FFFF;
        default: ;
      endcase
    end
    check({tag, " cfg_id"},  {24'h0, cfg_id}, {24'h0, s_id});
    check({tag, " cfg_ldr"}, cfg_ldr, s_ldr);
    check({tag, " cfg_dfr"}, cfg_dfr, s_dfr);
  endtask

  task automatic req(input string tag, input logic ext, input logic [1:0] sh,
                     input logic lg, input logic [31:0] d, input logic self_f);
    step(tag, 1'b0, 2'd3, 32'h0, ext, sh, lg, d, self_f);
  endtask

  task automatic wr(input string tag, input logic ext, input logic [1:0] sel,
                    input logic [31:0] wd);
    step(tag, 1'b1, sel, wd, ext, 2'd0, 1'b0, 32'h0000_1234, 1'b0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd3; cfg_wdata = '0; ext_mode = 1'b0;
    req_short = 2'd0; req_logical = 1'b0; req_dest = '0; req_from_self = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    s_id = 8'h03; s_ldr = 32'h0; s_dfr = 32'hFFFF_FFFF;
    check("R1 cfg_id",  {24'h0, cfg_id}, 32'h03);
    check("R1 cfg_ldr", cfg_ldr, 32'h0);
    check("R1 cfg_dfr", cfg_dfr, 32'hFFFF_FFFF);
    check("R1 match",   {31'h0, match}, 32'h0);
    check("R1 model_err", {31'h0, model_err}, 32'h0);

    // R3 physical, compact
    req("R3 bcast",  1'b0, 2'd0, 1'b0, 32'hABCD_00FF, 1'b0);
    req("R3 own id", 1'b0, 2'd0, 1'b0, 32'h0000_0003, 1'b0);
    req("R3 miss",   1'b0, 2'd0, 1'b0, 32'h0000_0004, 1'b0);
    // R10 writes and masking
    wr("R10 id write",  1'b0, 2'd0, 32'h2A12_3456);
    wr("R10 ldr write", 1'b0, 2'd1, 32'h81FF_FFFF);
    wr("R10 sel none",  1'b0, 2'd3, 32'h5555_5555);
    // R5 flat
    req("R5 flat hit",  1'b0, 2'd0, 1'b1, 32'h0000_0001, 1'b0);
    req("R5 flat miss", 1'b0, 2'd0, 1'b1, 32'h0000_007E, 1'b0);
    // R6 cluster
    wr("R10 dfr write", 1'b0, 2'd2, 32'h0000_0000);
    wr("R10 ldr 35",    1'b0, 2'd1, 32'h3500_0000);
    req("R6 cluster hit",       1'b0, 2'd0, 1'b1, 32'h0000_0031, 1'b0);
    req("R6 cluster other",     1'b0, 2'd0, 1'b1, 32'h0000_0025, 1'b0);
    req("R6 cluster no member", 1'b0, 2'd0, 1'b1, 32'h0000_003A, 1'b0);
    // R7 unknown model
    wr("R10 dfr bad", 1'b0, 2'd2, 32'h5000_0000);
    req("R7 bad model logical",  1'b0, 2'd0, 1'b1, 32'h0000_00FF, 1'b0);
    req("R7 bad model physical", 1'b0, 2'd0, 1'b0, 32'h0000_00FF, 1'b0);
    // R8 shorthands
    req("R8 self from self",   1'b0, 2'd1, 1'b1, 32'h0, 1'b1);
    req("R8 self from other",  1'b0, 2'd1, 1'b0, 32'hFF, 1'b0);
    req("R8 all",              1'b0, 2'd2, 1'b1, 32'h0, 1'b1);
    req("R8 others from self", 1'b0, 2'd3, 1'b0, 32'h0, 1'b1);
    req("R8 others from peer", 1'b0, 2'd3, 1'b0, 32'h0, 1'b0);
    // R9 / R4 / R11 extended
    req("R9 enter ext", 1'b1, 2'd0, 1'b1, 32'h0000_0400, 1'b0);
    req("R9 ext slot miss", 1'b1, 2'd0, 1'b1, 32'h0010_0000, 1'b0);
    req("R9 ext cluster",   1'b1, 2'd0, 1'b1, 32'h0020_0000, 1'b0);
    req("R4 ext id",        1'b1, 2'd0, 1'b0, 32'h0000_002A, 1'b0);
    req("R4 ext bcast",     1'b1, 2'd0, 1'b0, 32'h0000_00FF, 1'b0);
    req("R4 ext upper set", 1'b1, 2'd0, 1'b0, 32'h0000_012A, 1'b0);
    wr("R11 id ignored",  1'b1, 2'd0, 32'h5500_0000);
    wr("R11 dfr ignored", 1'b1, 2'd2, 32'hF000_0000);
    wr("R11 ldr replaced", 1'b1, 2'd1, 32'hEE00_0000);
    req("R9 leave ext", 1'b0, 2'd0, 1'b0, 32'h0000_002A, 1'b0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic        we, ext, lg, sf;
      logic [1:0]  sel, sh;
      logic [31:0] wd, d;
      int          pick;
      ext = ($urandom % 8) == 0;
      we  = ($urandom % 4) == 0;
      sel = 2'($urandom % 4);
      wd  = $urandom;
      pick = $urandom % 3;
      if (sel == 2'd2) wd[31:28] = (pick == 0) ? 4'hF : (pick == 1) ? 4'h0 : 4'($urandom);
      sh  = (($urandom % 3) == 0) ? 2'($urandom) : 2'd0;
      lg  = $urandom % 2;
      sf  = $urandom % 2;
      case ($urandom % 5)
        0: d = $urandom;
        1: d = (($urandom % 2) == 1) ? 32'hFF : {24'h0, s_id};
        2: d = {$urandom % 2 == 1 ? 24'h0 : 24'($urandom), s_id};
        3: d = {24'h0, s_ldr[31:28], 4'($urandom)};
        default: d = gen_ldr(s_id) & $urandom;
      endcase
      step($sformatf("R2 rand %0d", i), we, sel, wd, ext, sh, lg, d, sf);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule